// File: doc/BRIEF.md
# Fall-Through Word Stack

This block is a small self-timed word store. A word is placed at the top position and then sinks toward the bottom. It moves one position per clock, and only into a position that is vacant. The result is a first-in first-out store that needs no read or write pointers. Each position keeps its own occupancy bit and decides locally whether its word advances. A vacancy created at the bottom climbs upward one position per clock.

The block sits between an input staging register and an output register. The producer presents a word with a write strobe. The write is accepted only while the top position is vacant. The consumer sees a valid flag and the word in the lowest position, and pulses a take strobe to remove it. The synchronous reset clears the occupancy bits only and leaves the stored data bits as they were.

Top module: `fts_stack`

## Requirements
- R1: While `rst` is high at a rising clock edge, every position becomes vacant: after the edge `top_empty` is 1 and `bottom_valid` is 0.
- R2: When `wr_en` is high and `top_empty` is 1 at an edge, `wr_data` is stored in the top position, and `top_empty` is 0 after that edge.
- R3: A word in position i moves to position i+1 at an edge when position i+1 was vacant before that edge. The decision looks only at occupancy before the edge. A single word written into an empty stack therefore raises `bottom_valid` DEPTH-1 edges after its write edge (13 for the default depth of 14).
- R4: Words leave in the order they were accepted. While `bottom_valid` is 1, `bottom_data` is the oldest word held, and it stays stable until it is taken.
- R5: The stack holds at most DEPTH words (14 by default). When all positions are occupied, `top_empty` is 0 and `wr_en` has no effect: draining a stack that was filled by continuous writes yields exactly DEPTH words.
- R6: `take` high while `bottom_valid` is 1 removes the bottom word, so `bottom_valid` is 0 after that edge. `take` while `bottom_valid` is 0 has no effect.
- R7: A write and a take in the same cycle neither lose nor duplicate a word.
- R8: Reset clears occupancy only. `bottom_data` keeps the last word that reached the bottom position through and after reset.
- R9: After a single take from a full stack, the vacancy climbs one position per edge, and `top_empty` rises DEPTH-1 edges after the take edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of occupancy |
| wr_en | input | 1 | Write strobe for the top position |
| wr_data | input | DATA_W | Word to write |
| top_empty | output | 1 | Top position vacant, write will be accepted |
| take | input | 1 | Remove the bottom word |
| bottom_valid | output | 1 | Bottom position holds a word |
| bottom_data | output | DATA_W | Word in the bottom position |

## Verification
An occupancy bit that is set or cleared wrongly inside the chain appears at the ports only once the affected word or vacancy has travelled to an end. It may take up to DEPTH-1 cycles to reach `bottom_valid` or `top_empty`. It then shows as a shifted arrival or vacancy time, a lost or repeated word in the output sequence, or an accepted count different from DEPTH. The bench therefore compares both flags and the bottom word every cycle against a behavioural queue model. It also measures the fall-through and climb-up latencies and the exact capacity directly. Data corruption during movement is caught when the word reaches the bottom, and the R8 check confirms that reset leaves the bottom data bits intact.

// File: rtl/fts_pkg.sv
package fts_pkg;
    localparam int unsigned DEF_DATA_W = 4;
    localparam int unsigned DEF_DEPTH  = 14;

    // A word may advance when it is present and the slot below is vacant.
    function automatic logic may_advance(input logic here, input logic below);
        return here & ~below;
    endfunction
endpackage

// File: rtl/fts_advance.sv
module fts_advance #(
    parameter int unsigned DEPTH = fts_pkg::DEF_DEPTH
) (
    input  logic [DEPTH-1:0] occ,
    input  logic             wr_en,
    input  logic             take,
    output logic [DEPTH-1:0] load,
    output logic [DEPTH-1:0] leave
);
    localparam int unsigned LAST = DEPTH - 1;

    logic [LAST-1:0] step;

    genvar i;
    generate
        for (i = 0; i < LAST; i++) begin : g_step
            assign step[i] = fts_pkg::may_advance(occ[i], occ[i+1]);
        end
        for (i = 0; i < DEPTH; i++) begin : g_ctl
            if (i == 0) begin : g_top
                assign load[i] = wr_en & ~occ[0];
            end else begin : g_mid_load
                assign load[i] = step[i-1];
            end
            if (i == LAST) begin : g_bot
                assign leave[i] = take & occ[LAST];
            end else begin : g_mid_leave
                assign leave[i] = step[i];
            end
        end
    endgenerate
endmodule

// File: rtl/fts_cell.sv
module fts_cell #(
    parameter int unsigned DATA_W = fts_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              leave,
    output logic              full,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
        end else if (load) begin
            full <= 1'b1;
        end else if (leave) begin
            full <= 1'b0;
        end
    end

    // Data bits carry no reset: only occupancy is initialised.
    always_ff @(posedge clk) begin
        if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/fts_stack.sv
module fts_stack #(
    parameter int unsigned DATA_W = fts_pkg::DEF_DATA_W,
    parameter int unsigned DEPTH  = fts_pkg::DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              top_empty,
    input  logic              take,
    output logic              bottom_valid,
    output logic [DATA_W-1:0] bottom_data
);
    localparam int unsigned LAST = DEPTH - 1;

    logic [DEPTH-1:0]  occ;
    logic [DEPTH-1:0]  load;
    logic [DEPTH-1:0]  leave;
    logic [DATA_W-1:0] cell_q [DEPTH];

    fts_advance #(.DEPTH(DEPTH)) u_adv (
        .occ   (occ),
        .wr_en (wr_en),
        .take  (take),
        .load  (load),
        .leave (leave)
    );

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_cell
            logic [DATA_W-1:0] cell_in;
            if (i == 0) begin : g_src_top
                assign cell_in = wr_data;
            end else begin : g_src_above
                assign cell_in = cell_q[i-1];
            end
            fts_cell #(.DATA_W(DATA_W)) u_cell (
                .clk   (clk),
                .rst   (rst),
                .load  (load[i]),
                .din   (cell_in),
                .leave (leave[i]),
                .full  (occ[i]),
                .q     (cell_q[i])
            );
        end
    endgenerate

    assign top_empty    = ~occ[0];
    assign bottom_valid = occ[LAST];
    assign bottom_data  = cell_q[LAST];
endmodule

// File: rtl/fts_stack_chk.sv
module fts_stack_chk #(
    parameter int unsigned DATA_W = fts_pkg::DEF_DATA_W,
    parameter int unsigned DEPTH  = fts_pkg::DEF_DEPTH
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              take,
    input logic              top_empty,
    input logic              bottom_valid,
    input logic [DATA_W-1:0] bottom_data,
    input logic [DEPTH-1:0]  occ
);
    AST_WRITE_FILLS_TOP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && top_empty) |=> !top_empty); // R2

    AST_TAKE_CLEARS_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (take && bottom_valid) |=> !bottom_valid); // R6

    AST_BOTTOM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bottom_valid && !take) |=> (bottom_valid && $stable(bottom_data))); // R4

    AST_ARRIVE_FROM_ABOVE: assert property (@(posedge clk) disable iff (rst)
        $rose(bottom_valid) |-> $past(occ[DEPTH-2])); // R3

    AST_TOP_DESCENDS: assert property (@(posedge clk) disable iff (rst)
        (!top_empty && !occ[1]) |=> occ[1]); // R3
endmodule

bind fts_stack fts_stack_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .take         (take),
    .top_empty    (top_empty),
    .bottom_valid (bottom_valid),
    .bottom_data  (bottom_data),
    .occ          (occ)
);

// File: tb/fts_stack_tb.sv
module fts_stack_tb;
    localparam int DW = 4;
    localparam int D  = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          take = 1'b0;
    logic [DW-1:0] wr_data = '0;
    wire           top_empty;
    wire           bottom_valid;
    wire [DW-1:0]  bottom_data;

    always #4 clk = ~clk;

    fts_stack #(.DATA_W(DW), .DEPTH(D)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .top_empty    (top_empty),
        .take         (take),
        .bottom_valid (bottom_valid),
        .bottom_data  (bottom_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // Behavioural model: queue of words with positions, oldest first.
    int          m_pos [$];
    logic [DW-1:0] m_dat [$];
    logic [DW-1:0] m_bot = '0;
    bit          m_bot_known = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int  n;
        int  np [$];
        bit  top_occ;
        int  p;
        started = 1'b1;
        if (rst) begin
            m_pos.delete();
            m_dat.delete();
        end else begin
            n = m_pos.size();
            top_occ = (n > 0) && (m_pos[n-1] == 0);
            np.delete();
            for (int j = 0; j < n; j++) begin
                p = m_pos[j];
                if (p < D-1 && (j == 0 || m_pos[j-1] != p+1)) begin
                    np.push_back(p+1);
                    if (p+1 == D-1) begin
                        m_bot = m_dat[j];
                        m_bot_known = 1'b1;
                    end
                end else begin
                    np.push_back(p);
                end
            end
            if (take && n > 0 && m_pos[0] == D-1) begin
                np.delete(0);
                m_dat.delete(0);
            end
            m_pos = np;
            if (wr_en && !top_occ) begin
                m_pos.push_back(0);
                m_dat.push_back(wr_data);
            end
        end
    end

    always @(negedge clk) begin
        int n;
        bit e_te;
        bit e_bv;
        if (started && !done) begin
            n = m_pos.size();
            e_te = !((n > 0) && (m_pos[n-1] == 0));
            e_bv = (n > 0) && (m_pos[0] == D-1);
            check("R2/R5 top_empty vs model", {31'd0, top_empty}, {31'd0, e_te});
            check("R3/R6 bottom_valid vs model", {31'd0, bottom_valid}, {31'd0, e_bv});
            if (e_bv)
                check("R4/R7 bottom_data vs model", {28'd0, bottom_data}, {28'd0, m_dat[0]});
            else if (m_bot_known)
                check("R8 bottom_data retained", {28'd0, bottom_data}, {28'd0, m_bot});
        end
    end

    task automatic step(input logic w, input logic [DW-1:0] d, input logic t);
        wr_en = w;
        wr_data = d;
        take = t;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int k;
        int cnt;
        logic t;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 top_empty after reset", {31'd0, top_empty}, 32'd1);
        check("R1 bottom_valid after reset", {31'd0, bottom_valid}, 32'd0);
        rst = 1'b0;

        // R2 and R3: single word, fall-through latency
        step(1'b1, 4'hA, 1'b0);
        check("R2 top occupied after write", {31'd0, top_empty}, 32'd0);
        k = 0;
        while (!bottom_valid && k < 40) begin
            step(1'b0, '0, 1'b0);
            k++;
        end
        check("R3 fall-through latency", k, D-1);
        check("R4 first word data", {28'd0, bottom_data}, 32'hA);

        // R6: take, then takes on empty are ignored
        step(1'b0, '0, 1'b1);
        check("R6 take clears bottom", {31'd0, bottom_valid}, 32'd0);
        repeat (3) step(1'b0, '0, 1'b1);
        check("R6 empty take ignored valid", {31'd0, bottom_valid}, 32'd0);
        check("R6 empty take ignored top", {31'd0, top_empty}, 32'd1);

        // R5: fill with continuous writes, count what drains
        for (int i = 0; i < 40; i++) step(1'b1, 4'(i), 1'b0);
        check("R5 full top not empty", {31'd0, top_empty}, 32'd0);
        check("R5 full bottom valid", {31'd0, bottom_valid}, 32'd1);
        repeat (4) step(1'b1, 4'hF, 1'b0);
        cnt = 0;
        for (int i = 0; i < 80; i++) begin
            t = bottom_valid;
            if (t) cnt++;
            step(1'b0, '0, t);
        end
        check("R5 capacity drained", cnt, D);

        // R9: one take from full, vacancy climbs
        for (int i = 0; i < 40; i++) step(1'b1, 4'(i + 3), 1'b0);
        step(1'b0, '0, 1'b1);
        k = 0;
        while (!top_empty && k < 40) begin
            step(1'b0, '0, 1'b0);
            k++;
        end
        check("R9 vacancy climb latency", k, D-1);
        for (int i = 0; i < 80; i++) step(1'b0, '0, bottom_valid);

        // R7: streaming write and take together
        for (int i = 0; i < 300; i++) step(1'b1, 4'(i * 7), bottom_valid);
        for (int i = 0; i < 80; i++) step(1'b0, '0, bottom_valid);

        // R8: reset keeps bottom data
        step(1'b1, 4'h5, 1'b0);
        repeat (20) step(1'b0, '0, 1'b0);
        check("R8 word at bottom", {28'd0, bottom_data}, 32'h5);
        rst = 1'b1;
        repeat (2) step(1'b0, '0, 1'b0);
        check("R8 reset clears valid", {31'd0, bottom_valid}, 32'd0);
        check("R8 reset keeps data", {28'd0, bottom_data}, 32'h5);
        rst = 1'b0;
        step(1'b0, '0, 1'b0);
        check("R1 top empty after second reset", {31'd0, top_empty}, 32'd1);

        // Mixed random traffic, compared by the model (R4, R7)
        for (int i = 0; i < 4000; i++)
            step(1'($urandom % 2), 4'($urandom), 1'(($urandom % 3) != 0));
        for (int i = 0; i < 80; i++) step(1'b0, '0, bottom_valid);

        finish_run();
    end
endmodule